// File: doc/BRIEF.md
# Sampling Tap Drift Correction Controller

This block holds the sampling tap position that a receive delay line uses for a high-speed card interface. After the tap has been loaded with a tuning result, the block accepts correction requests from the sampling-point monitors and nudges the tap by one step, up or down. The tap wraps around the configured tap count in both directions. A condition that cannot be corrected by a single step raises a one-cycle retune request instead.

The request source depends on the mode. In the normal single-edge modes, the block reads a three-bit request word with down, up and error flags. In the double-data-rate strobe-based mode, the block reads a 32-bit command compare status and uses only two of its bits. An automatic-correction setting limits the block's role to spotting the error flag. A 4-tap setting makes the value sent to the delay line half the internal tap. Correction pauses while a tuning sweep runs. It is also skipped in strobe mode when 4-tap operation is active, because a retune in that state would select the same taps again.

Every request that the block acts on produces a one-cycle clear pulse for the upstream request register. A tap change produces a one-cycle update strobe.

Top module: `tapdrift_ctrl`

## Requirements
- R1: After synchronous reset the tap is 0, and `tap_upd`, `retune_req` and `req_clear` are low.
- R2: A cycle with `tap_load` high sets the tap to `tap_load_val` modulo `TAPS`. Any request edge in that same cycle is dropped, with no update, retune or clear.
- R3: In manual normal mode (`auto_en`=0, `strobe_mode`=0), request word bit 2 (error) raises `retune_req` and leaves the tap unchanged, whatever bits 1 and 0 hold.
- R4: In manual normal mode without the error bit, bit 1 (up) increments the tap and bit 0 (down) decrements it. When both are set, up wins. When neither is set, nothing changes.
- R5: Increment from `TAPS`-1 gives 0, and decrement from 0 gives `TAPS`-1.
- R6: In manual strobe mode, only compare bit 24 (up) and bit 8 (down) are used. The request word and all other compare bits have no effect.
- R7: In manual strobe mode, bits 24 and 8 both set raise `retune_req` with no tap change. Neither set leaves the tap unchanged.
- R8: `tap_out` equals the tap shifted right by one when `four_tap` is 1, and equals the tap otherwise.
- R9: A request is acted on once per rising edge of `req_valid`, however long the level stays high. Each tap change comes with a single-cycle `tap_upd`, in the cycle the new tap appears.
- R10: In manual modes, every request that is acted on pulses `req_clear` once, in the same cycle as its result.
- R11: While `sweep_active` is 1, and while both `strobe_mode` and `four_tap` are 1, a request edge changes nothing: no tap change, no update, no retune and no clear.
- R12: With `auto_en`=1, only request bit 2 is examined. When it is set, `retune_req` and `req_clear` pulse together. The up and down bits never move the tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_load | input | 1 | Load the tap from `tap_load_val` |
| tap_load_val | input | TAPW | Tap value to load (tuning result) |
| req_valid | input | 1 | Request present; its rising edge is acted on |
| req_word | input | 3 | Normal-mode request: bit0 down, bit1 up, bit2 error |
| cmp_word | input | 32 | Strobe-mode compare status: bit8 down, bit24 up |
| strobe_mode | input | 1 | Double-data-rate strobe-based mode selects `cmp_word` |
| four_tap | input | 1 | 4-tap operation: halve the output tap |
| auto_en | input | 1 | Automatic correction: error bit only |
| sweep_active | input | 1 | Tuning sweep in progress; correction skipped |
| tap_cur | output | TAPW | Current internal tap |
| tap_out | output | TAPW | Tap value sent to the delay line |
| tap_upd | output | 1 | One-cycle strobe on a tap change |
| retune_req | output | 1 | One-cycle full-retune request |
| req_clear | output | 1 | One-cycle clear for the request register |

## Verification
All results of a request are registered once, so `tap_cur`, `tap_upd`, `retune_req` and `req_clear` change on the first rising clock edge at which `req_valid` is high after having been low. A load likewise appears one edge after `tap_load` is seen. `tap_out` follows the tap and `four_tap` without further delay. The bench changes inputs on falling edges and reads every output on the falling edge that follows the acting rising edge. It then lowers `req_valid` so that the next edge shows the strobes have returned to zero. The sweep covers every starting tap, every request word, every compare-bit combination and every mode setting.

// File: rtl/tapdrift_pkg.sv
package tapdrift_pkg;

    localparam int REQ_W        = 3;
    localparam int CMP_W        = 32;
    localparam int REQ_DOWN_BIT = 0;
    localparam int REQ_UP_BIT   = 1;
    localparam int REQ_ERR_BIT  = 2;
    localparam int CMP_DOWN_BIT = 8;
    localparam int CMP_UP_BIT   = 24;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_UP     = 2'd1,
        ACT_DOWN   = 2'd2,
        ACT_RETUNE = 2'd3
    } tap_act_e;

    typedef struct packed {
        tap_act_e act;
        logic     clear;
    } tap_dec_t;

    localparam tap_dec_t DEC_IDLE = '{act: ACT_NONE, clear: 1'b0};

    // Single-edge modes: error first, then up, then down.
    function automatic tap_dec_t decode_normal(input logic [REQ_W-1:0] rw);
        tap_dec_t d;
        d.clear = 1'b1;
        if (rw[REQ_ERR_BIT])      d.act = ACT_RETUNE;
        else if (rw[REQ_UP_BIT])  d.act = ACT_UP;
        else if (rw[REQ_DOWN_BIT]) d.act = ACT_DOWN;
        else                      d.act = ACT_NONE;
        return d;
    endfunction

    // Strobe-based mode: command compare bits only; both set is an error.
    function automatic tap_dec_t decode_strobe(input logic [CMP_W-1:0] cw);
        tap_dec_t d;
        d.clear = 1'b1;
        unique case ({cw[CMP_UP_BIT], cw[CMP_DOWN_BIT]})
            2'b11:   d.act = ACT_RETUNE;
            2'b10:   d.act = ACT_UP;
            2'b01:   d.act = ACT_DOWN;
            default: d.act = ACT_NONE;
        endcase
        return d;
    endfunction

    // Automatic correction: only the error flag matters.
    function automatic tap_dec_t decode_auto(input logic [REQ_W-1:0] rw);
        tap_dec_t d;
        d.act   = rw[REQ_ERR_BIT] ? ACT_RETUNE : ACT_NONE;
        d.clear = rw[REQ_ERR_BIT];
        return d;
    endfunction

endpackage

// File: rtl/tapdrift_decode.sv
module tapdrift_decode
    import tapdrift_pkg::*;
(
    input  logic             fire,
    input  logic [REQ_W-1:0] req_word,
    input  logic [CMP_W-1:0] cmp_word,
    input  logic             strobe_mode,
    input  logic             four_tap,
    input  logic             auto_en,
    input  logic             sweep_active,
    output tap_dec_t         dec
);

    logic skip;
    assign skip = sweep_active | (strobe_mode & four_tap);

    always_comb begin
        if (!fire || skip)    dec = DEC_IDLE;
        else if (auto_en)     dec = decode_auto(req_word);
        else if (strobe_mode) dec = decode_strobe(cmp_word);
        else                  dec = decode_normal(req_word);
    end

endmodule

// File: rtl/tapdrift_step.sv
module tapdrift_step #(
    parameter int TAPS = 8,
    parameter int TAPW = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [TAPW-1:0] load_val,
    input  logic            inc,
    input  logic            dec,
    output logic [TAPW-1:0] tap
);

    localparam logic [TAPW-1:0] TOP      = TAPW'(TAPS - 1);
    localparam bit              IS_POW2  = ((TAPS & (TAPS - 1)) == 0);

    logic [TAPW-1:0] tap_plus;
    logic [TAPW-1:0] tap_minus;
    logic [TAPW-1:0] load_mod;

    generate
        if (IS_POW2) begin : g_pow2
            assign tap_plus  = tap + 1'b1;
            assign tap_minus = tap - 1'b1;
            assign load_mod  = load_val;
        end else begin : g_gen
            assign tap_plus  = (tap == TOP) ? '0 : tap + 1'b1;
            assign tap_minus = (tap == '0) ? TOP : tap - 1'b1;
            assign load_mod  = TAPW'(int'(load_val) % TAPS);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)       tap <= '0;
        else if (load) tap <= load_mod;
        else if (inc)  tap <= tap_plus;
        else if (dec)  tap <= tap_minus;
    end

    assert_tap_range_R5: assert property (@(posedge clk) disable iff (rst)
        int'(tap) < TAPS);

    assert_inc_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (inc && !load) |=> tap == (($past(tap) == TOP) ? '0 : $past(tap) + 1'b1));

    assert_dec_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc && !load) |=> tap == (($past(tap) == '0) ? TOP : $past(tap) - 1'b1));

endmodule

// File: rtl/tapdrift_ctrl.sv
module tapdrift_ctrl
    import tapdrift_pkg::*;
#(
    parameter int TAPS = 8,
    parameter int TAPW = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tap_load,
    input  logic [TAPW-1:0]  tap_load_val,
    input  logic             req_valid,
    input  logic [REQ_W-1:0] req_word,
    input  logic [CMP_W-1:0] cmp_word,
    input  logic             strobe_mode,
    input  logic             four_tap,
    input  logic             auto_en,
    input  logic             sweep_active,
    output logic [TAPW-1:0]  tap_cur,
    output logic [TAPW-1:0]  tap_out,
    output logic             tap_upd,
    output logic             retune_req,
    output logic             req_clear
);

    logic     req_q;
    logic     fire;
    tap_dec_t dec;
    logic     step_up;
    logic     step_dn;

    // Edge detect: one action per request pulse; a load masks the edge.
    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= req_valid;
    end
    assign fire = req_valid & ~req_q & ~tap_load;

    tapdrift_decode u_decode (
        .fire         (fire),
        .req_word     (req_word),
        .cmp_word     (cmp_word),
        .strobe_mode  (strobe_mode),
        .four_tap     (four_tap),
        .auto_en      (auto_en),
        .sweep_active (sweep_active),
        .dec          (dec)
    );

    assign step_up = (dec.act == ACT_UP);
    assign step_dn = (dec.act == ACT_DOWN);

    tapdrift_step #(.TAPS(TAPS), .TAPW(TAPW)) u_step (
        .clk      (clk),
        .rst      (rst),
        .load     (tap_load),
        .load_val (tap_load_val),
        .inc      (step_up),
        .dec      (step_dn),
        .tap      (tap_cur)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_upd    <= 1'b0;
            retune_req <= 1'b0;
            req_clear  <= 1'b0;
        end else begin
            tap_upd    <= step_up | step_dn;
            retune_req <= (dec.act == ACT_RETUNE);
            req_clear  <= dec.clear;
        end
    end

    generate
        if (TAPW > 1) begin : g_half
            assign tap_out = four_tap ? {1'b0, tap_cur[TAPW-1:1]} : tap_cur;
        end else begin : g_single
            assign tap_out = four_tap ? 1'b0 : tap_cur;
        end
    endgenerate

    assert_upd_retune_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(tap_upd && retune_req));

    assert_upd_single_R9: assert property (@(posedge clk) disable iff (rst)
        tap_upd |=> !tap_upd);

    assert_tap_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!tap_upd && !$past(tap_load)) |-> $stable(tap_cur));

    assert_sweep_skip_R11: assert property (@(posedge clk) disable iff (rst)
        $past(sweep_active) |-> (!tap_upd && !retune_req && !req_clear));

    assert_auto_clear_R12: assert property (@(posedge clk) disable iff (rst)
        ($past(auto_en) && req_clear) |-> (retune_req && !tap_upd));

endmodule

// File: tb/tapdrift_ctrl_tb.sv
module tapdrift_ctrl_tb_top;

    localparam int TAPS = 8;
    localparam int TAPW = 3;

    logic            clk = 1'b0;
    logic            rst;
    logic            tap_load;
    logic [TAPW-1:0] tap_load_val;
    logic            req_valid;
    logic [2:0]      req_word;
    logic [31:0]     cmp_word;
    logic            strobe_mode, four_tap, auto_en, sweep_active;
    logic [TAPW-1:0] tap_cur, tap_out;
    logic            tap_upd, retune_req, req_clear;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tapdrift_ctrl #(.TAPS(TAPS), .TAPW(TAPW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .tap_load     (tap_load),
        .tap_load_val (tap_load_val),
        .req_valid    (req_valid),
        .req_word     (req_word),
        .cmp_word     (cmp_word),
        .strobe_mode  (strobe_mode),
        .four_tap     (four_tap),
        .auto_en      (auto_en),
        .sweep_active (sweep_active),
        .tap_cur      (tap_cur),
        .tap_out      (tap_out),
        .tap_upd      (tap_upd),
        .retune_req   (retune_req),
        .req_clear    (req_clear)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Load tap t, then raise a request edge with the given fields.
    task automatic run_req(input int t, input logic [2:0] rw, input logic [31:0] cw,
                           input bit sm, input bit ft, input bit ae, input bit sw);
        tap_load = 1'b1; tap_load_val = TAPW'(t); req_valid = 1'b0;
        tick();
        tap_load = 1'b0;
        req_word = rw; cmp_word = cw;
        strobe_mode = sm; four_tap = ft; auto_en = ae; sweep_active = sw;
        req_valid = 1'b1;
        tick();
    endtask

    initial begin
        rst = 1'b1; tap_load = 1'b0; tap_load_val = '0; req_valid = 1'b0;
        req_word = '0; cmp_word = '0;
        strobe_mode = 1'b0; four_tap = 1'b0; auto_en = 1'b0; sweep_active = 1'b0;
        tick(); tick();
        // R1 reset state
        check("R1 tap", int'(tap_cur), 0);
        check("R1 upd", int'(tap_upd), 0);
        check("R1 retune", int'(retune_req), 0);
        check("R1 clear", int'(req_clear), 0);
        rst = 1'b0;
        tick();

        // Near-exhaustive sweep
        for (int md = 0; md < 16; md++) begin
            for (int rw = 0; rw < 8; rw++) begin
                for (int cb = 0; cb < 4; cb++) begin
                    for (int t = 0; t < TAPS; t++) begin
                        bit sm = md[0], ft = md[1], ae = md[2], sw = md[3];
                        logic [31:0] cw;
                        int e_tap, e_upd, e_ret, e_clr, act;
                        string ttag, rtag;
                        cw = 32'h5A00_0055 | (cb[0] ? 32'h0000_0100 : 32'h0)
                                           | (cb[1] ? 32'h0100_0000 : 32'h0);
                        act = 0; e_clr = 0; e_ret = 0;
                        if (sw || (sm && ft)) begin
                            act = 0; ttag = "R11"; rtag = "R11";
                        end else if (ae) begin
                            ttag = "R12"; rtag = "R12";
                            if (rw[2]) begin act = 3; e_clr = 1; end
                        end else if (sm) begin
                            ttag = "R6"; rtag = "R7"; e_clr = 1;
                            if (cb == 3) act = 3; else if (cb == 2) act = 1;
                            else if (cb == 1) act = 2;
                        end else begin
                            ttag = "R4"; rtag = "R3"; e_clr = 1;
                            if (rw[2]) act = 3; else if (rw[1]) act = 1;
                            else if (rw[0]) act = 2;
                        end
                        e_tap = t;
                        if (act == 1) e_tap = (t + 1) % TAPS;
                        if (act == 2) e_tap = (t + TAPS - 1) % TAPS;
                        if ((act == 1 || act == 2) && (t == 0 || t == TAPS - 1))
                            ttag = {ttag, "/R5"};
                        e_upd = (act == 1 || act == 2) ? 1 : 0;
                        e_ret = (act == 3) ? 1 : 0;
                        run_req(t, 3'(rw), cw, sm, ft, ae, sw);
                        check({ttag, " tap"}, int'(tap_cur), e_tap);
                        check("R9 upd", int'(tap_upd), e_upd);
                        check({rtag, " retune"}, int'(retune_req), e_ret);
                        check("R10 clear", int'(req_clear), e_clr);
                        check("R8 tap_out", int'(tap_out), ft ? e_tap / 2 : e_tap);
                    end
                end
            end
        end

        // R9: level held high acts only once
        run_req(3, 3'b010, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R9 first", int'(tap_cur), 4);
        tick();
        check("R9 held upd", int'(tap_upd), 0);
        tick();
        check("R9 held tap", int'(tap_cur), 4);
        check("R10 held clear", int'(req_clear), 0);
        req_valid = 1'b0;
        tick();

        // R2: load in the same cycle as a request edge wins
        tap_load = 1'b1; tap_load_val = 3'd6; req_word = 3'b010; req_valid = 1'b1;
        tick();
        check("R2 load", int'(tap_cur), 6);
        check("R2 no upd", int'(tap_upd), 0);
        check("R2 no clear", int'(req_clear), 0);
        tap_load = 1'b0; req_valid = 1'b0;
        tick();
        check("R2 hold", int'(tap_cur), 6);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule